// File: doc/BRIEF.md
# Receive Character Decoder with Raw Bypass

This block sits behind a character framer. It takes one framed character per character clock, marked by a valid strobe. With decoding on, it turns a 10-bit transmission character into an 8-bit value and a flag that tells control codes apart from data. It also reports coding violations and running-disparity violations. With decoding off, the character goes to the output register unchanged, either 10 or 12 bits wide, as a width select picks.

Every mode has the same latency: a character applied on one rising edge appears at the outputs after that edge, together with a one-cycle valid pulse. The outputs hold their last value while no character is offered. Running disparity is tracked only for characters that are decoded, so raw traffic in bypass does not disturb it.

Top module: `rx_char_decoder`

## Requirements
- R1: After reset `validOut`, `dataOut`, `specialOut` and `errOut` are all 0, and running disparity starts negative.
- R2: A character accepted with `charValid` high gives `validOut` high in the following cycle. A cycle with `charValid` low gives `validOut` low in the following cycle, and all other outputs keep their values.
- R3: In decode mode (`decEn` high) `charIn[9:4]` is the 6-bit sub-block (bit 9 sent first) and `charIn[3:0]` is the 4-bit sub-block. A valid data character gives `dataOut[7:0]` = {3-bit sub-block value, 5-bit sub-block value}, with `specialOut` 0 and `errOut` 0.
- R4: The twelve control codes decode with `specialOut` 1. These are the eight codes whose 5-bit value is 28 (6-bit pattern 001111 or 110000), and the codes with 3-bit value 7 on 5-bit values 23, 27, 29 and 30 (4-bit pattern 0111 or 1000).
- R5: A 6-bit or 4-bit pattern that belongs to no code is an error: `errOut` 1, `specialOut` 1, `dataOut[7:0]` = error byte (parameter, default 8'h00).
- R6: A sub-block whose disparity does not suit the current running disparity is an error, reported as in R5. Such sub-blocks are an unbalanced one of the same sign, 000111 at negative, 111000 at positive, 0011 at negative, and 1100 at positive.
- R7: Each decoded character, erroneous ones included, updates running disparity. An unbalanced sub-block sets it to the sign of its excess, and a balanced one leaves it unchanged. The 6-bit sub-block is applied first, then the 4-bit one.
- R8: With `decEn` low and `wide10` high, `dataOut` = {2'b00, `charIn[9:0]`}, with `specialOut` and `errOut` 0. Running disparity is unchanged.
- R9: With `decEn` low and `wide10` low, `dataOut` = `charIn[11:0]`, with `specialOut` and `errOut` 0. Running disparity is unchanged.
- R10: In decode mode `dataOut[11:8]` is 0 and `charIn[11:10]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | A framed character is present this cycle |
| charIn | input | 12 | Framed character |
| decEn | input | 1 | 1 = decode, 0 = raw bypass |
| wide10 | input | 1 | Bypass width: 1 = 10 bits, 0 = 12 bits |
| validOut | output | 1 | Output character strobe |
| dataOut | output | 12 | Decoded byte (zero-extended) or raw character |
| specialOut | output | 1 | Control code, or error |
| errOut | output | 1 | Code or disparity violation |

## Verification
The decoder is driven by streams built with a bench-side encoder that follows the running disparity. These streams mix random data bytes with every control code in both polarities, so each 6-bit and 4-bit table entry is seen from both disparity sides. Invalid sub-blocks (no ones, four ones outside the table, all-ones 4-bit) show that violations are separate from disparity faults. Characters encoded for the opposite disparity must be flagged. Bypass bursts at both widths, placed between decoded characters, show whether bypass disturbs running disparity: a wrong update would turn the next valid character into a false error.

// File: rtl/rx_char_pkg.sv
package rx_char_pkg;
  typedef struct packed {
    logic load;
    logic decode;
    logic pass10;
    logic pass12;
  } strobe_t;
endpackage

// File: rtl/rx_char_ctrl.sv
module rx_char_ctrl
  import rx_char_pkg::*;
(
  input  logic    charValid,
  input  logic    decEn,
  input  logic    wide10,
  output strobe_t strobes
);
  always_comb begin
    strobes.load   = charValid;
    strobes.decode = charValid && decEn;
    strobes.pass10 = charValid && !decEn && wide10;
    strobes.pass12 = charValid && !decEn && !wide10;
  end
endmodule

// File: rtl/rx_char_dp.sv
module rx_char_dp
  import rx_char_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ERR_BYTE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [RAW_W-1:0]  charIn,
  output logic              validOut,
  output logic [RAW_W-1:0]  dataOut,
  output logic              specialOut,
  output logic              errOut
);
  localparam int HI_W = CODE_W - 4;

  function automatic logic [5:0] dec6(input logic [5:0] s);
    case (s)
      6'b100111, 6'b011000: dec6 = {1'b1, 5'd0};
      6'b011101, 6'b100010: dec6 = {1'b1, 5'd1};
      6'b101101, 6'b010010: dec6 = {1'b1, 5'd2};
      6'b110001:            dec6 = {1'b1, 5'd3};
      6'b110101, 6'b001010: dec6 = {1'b1, 5'd4};
      6'b101001:            dec6 = {1'b1, 5'd5};
      6'b011001:            dec6 = {1'b1, 5'd6};
      6'b111000, 6'b000111: dec6 = {1'b1, 5'd7};
      6'b111001, 6'b000110: dec6 = {1'b1, 5'd8};
      6'b100101:            dec6 = {1'b1, 5'd9};
      6'b010101:            dec6 = {1'b1, 5'd10};
      6'b110100:            dec6 = {1'b1, 5'd11};
      6'b001101:            dec6 = {1'b1, 5'd12};
      6'b101100:            dec6 = {1'b1, 5'd13};
      6'b011100:            dec6 = {1'b1, 5'd14};
      6'b010111, 6'b101000: dec6 = {1'b1, 5'd15};
      6'b011011, 6'b100100: dec6 = {1'b1, 5'd16};
      6'b100011:            dec6 = {1'b1, 5'd17};
      6'b010011:            dec6 = {1'b1, 5'd18};
      6'b110010:            dec6 = {1'b1, 5'd19};
      6'b001011:            dec6 = {1'b1, 5'd20};
      6'b101010:            dec6 = {1'b1, 5'd21};
      6'b011010:            dec6 = {1'b1, 5'd22};
      6'b111010, 6'b000101: dec6 = {1'b1, 5'd23};
      6'b110011, 6'b001100: dec6 = {1'b1, 5'd24};
      6'b100110:            dec6 = {1'b1, 5'd25};
      6'b010110:            dec6 = {1'b1, 5'd26};
      6'b110110, 6'b001001: dec6 = {1'b1, 5'd27};
      6'b001110:            dec6 = {1'b1, 5'd28};
      6'b101110, 6'b010001: dec6 = {1'b1, 5'd29};
      6'b011110, 6'b100001: dec6 = {1'b1, 5'd30};
      6'b101011, 6'b010100: dec6 = {1'b1, 5'd31};
      6'b001111, 6'b110000: dec6 = {1'b1, 5'd28};
      default:              dec6 = {1'b0, 5'd0};
    endcase
  endfunction

  function automatic logic [3:0] dec4(input logic [3:0] s);
    case (s)
      4'b1011, 4'b0100:                   dec4 = {1'b1, 3'd0};
      4'b1001:                            dec4 = {1'b1, 3'd1};
      4'b0101:                            dec4 = {1'b1, 3'd2};
      4'b1100, 4'b0011:                   dec4 = {1'b1, 3'd3};
      4'b1101, 4'b0010:                   dec4 = {1'b1, 3'd4};
      4'b1010:                            dec4 = {1'b1, 3'd5};
      4'b0110:                            dec4 = {1'b1, 3'd6};
      4'b1110, 4'b0001, 4'b0111, 4'b1000: dec4 = {1'b1, 3'd7};
      default:                            dec4 = {1'b0, 3'd0};
    endcase
  endfunction

  logic [HI_W-1:0] six;
  logic [3:0] four, fourAdj;
  logic [2:0] ones6, ones4;
  logic hit6, hit4, isK28, isKx7, rdPos, midPos, rdNext, dErr6, dErr4, codeErr;
  logic [4:0] valX;
  logic [2:0] valY;
  logic [BYTE_W-1:0] byteVal;

  always_comb begin
    six     = charIn[CODE_W-1:4];
    four    = charIn[3:0];
    ones6   = 3'($countones(six));
    ones4   = 3'($countones(four));
    {hit6, valX} = dec6(six);
    isK28   = (six == 6'b001111) || (six == 6'b110000);
    // after the negative control prefix the balanced 4-bit codes arrive inverted
    fourAdj = (six == 6'b110000) ? ~four : four;
    {hit4, valY} = dec4(fourAdj);
    isKx7   = ((four == 4'b0111) || (four == 4'b1000)) &&
              ((valX == 5'd23) || (valX == 5'd27) || (valX == 5'd29) || (valX == 5'd30));
    dErr6   = (!rdPos && ones6 < 3'd3) || (rdPos && ones6 > 3'd3) ||
              (!rdPos && six == 6'b000111) || (rdPos && six == 6'b111000);
    midPos  = (ones6 > 3'd3) ? 1'b1 : (ones6 < 3'd3) ? 1'b0 : rdPos;
    dErr4   = (!midPos && ones4 < 3'd2) || (midPos && ones4 > 3'd2) ||
              (!midPos && four == 4'b0011) || (midPos && four == 4'b1100);
    rdNext  = (ones4 > 3'd2) ? 1'b1 : (ones4 < 3'd2) ? 1'b0 : midPos;
    codeErr = !hit6 || !hit4 || dErr6 || dErr4;
    byteVal = codeErr ? ERR_BYTE : BYTE_W'({valY, valX});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut   <= 1'b0;
      dataOut    <= '0;
      specialOut <= 1'b0;
      errOut     <= 1'b0;
      rdPos      <= 1'b0;
    end else begin
      validOut <= strobes.load;
      if (strobes.decode) begin
        rdPos      <= rdNext;
        dataOut    <= RAW_W'(byteVal);
        specialOut <= codeErr || isK28 || isKx7;
        errOut     <= codeErr;
      end else if (strobes.pass10) begin
        dataOut    <= RAW_W'(charIn[CODE_W-1:0]);
        specialOut <= 1'b0;
        errOut     <= 1'b0;
      end else if (strobes.pass12) begin
        dataOut    <= charIn;
        specialOut <= 1'b0;
        errOut     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_char_decoder.sv
module rx_char_decoder
  import rx_char_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ERR_BYTE = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic [RAW_W-1:0] charIn,
  input  logic             decEn,
  input  logic             wide10,
  output logic             validOut,
  output logic [RAW_W-1:0] dataOut,
  output logic             specialOut,
  output logic             errOut
);
  strobe_t strobes;

  rx_char_ctrl ctrl_i (
    .charValid(charValid), .decEn(decEn), .wide10(wide10), .strobes(strobes)
  );

  rx_char_dp #(.RAW_W(RAW_W), .CODE_W(CODE_W), .BYTE_W(BYTE_W), .ERR_BYTE(ERR_BYTE)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .charIn(charIn),
    .validOut(validOut), .dataOut(dataOut), .specialOut(specialOut), .errOut(errOut)
  );
endmodule

// File: rtl/rx_char_decoder_chk.sv
module rx_char_decoder_chk #(
  parameter int RAW_W  = 12,
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ERR_BYTE = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic             charValid,
  input logic [RAW_W-1:0] charIn,
  input logic             decEn,
  input logic             wide10,
  input logic             validOut,
  input logic [RAW_W-1:0] dataOut,
  input logic             specialOut,
  input logic             errOut
);
  assert_strobe_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> validOut);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !charValid |=> (!validOut && $stable(dataOut) && $stable(errOut) && $stable(specialOut)));

  assert_raw12_R9: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !decEn && !wide10) |=> (dataOut == $past(charIn) && !errOut && !specialOut));

  assert_raw10_R8: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !decEn && wide10) |=>
      (dataOut == RAW_W'($past(charIn[CODE_W-1:0])) && !errOut && !specialOut));

  assert_err_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (specialOut && dataOut == RAW_W'(ERR_BYTE)));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && decEn) |=> (dataOut[RAW_W-1:BYTE_W] == '0));
endmodule

bind rx_char_decoder rx_char_decoder_chk #(
  .RAW_W(RAW_W), .CODE_W(CODE_W), .BYTE_W(BYTE_W), .ERR_BYTE(ERR_BYTE)
) chk_i (
  .clk(clk), .rstN(rstN), .charValid(charValid), .charIn(charIn), .decEn(decEn),
  .wide10(wide10), .validOut(validOut), .dataOut(dataOut), .specialOut(specialOut),
  .errOut(errOut)
);

// File: tb/rx_char_decoder_tb_top.sv
module rx_char_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic charValid = 1'b0;
  logic [11:0] charIn = '0;
  logic decEn = 1'b0;
  logic wide10 = 1'b0;
  logic validOut, specialOut, errOut;
  logic [11:0] dataOut;

  int checks = 0;
  int fails = 0;
  logic rd = 1'b0;
  logic pV = 1'b0, pS = 1'b0, pE = 1'b0;
  logic [11:0] pD = '0;
  string pTag = "R1 reset";

  always #2.5 clk = ~clk;

  rx_char_decoder dut_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charIn(charIn), .decEn(decEn),
    .wide10(wide10), .validOut(validOut), .dataOut(dataOut), .specialOut(specialOut),
    .errOut(errOut)
  );

  function automatic logic [5:0] m6(input logic [4:0] x);
    logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
      6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100,
      6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010,
      6'b011010, 6'b111010, 6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
      6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] m4(input logic [2:0] y);
    logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return t[y];
  endfunction

  // running disparity after a 10-bit character, sub-block by sub-block
  function automatic logic rdAfter(input logic r, input logic [9:0] c);
    int o6 = $countones(c[9:4]);
    int o4 = $countones(c[3:0]);
    logic m = (o6 > 3) ? 1'b1 : (o6 < 3) ? 1'b0 : r;
    return (o4 > 2) ? 1'b1 : (o4 < 2) ? 1'b0 : m;
  endfunction

  function automatic logic [9:0] enc(input logic [7:0] b, input logic k, input logic r);
    logic [4:0] x = b[4:0];
    logic [2:0] y = b[7:5];
    logic [5:0] s6 = (k && x == 5'd28) ? 6'b001111 : m6(x);
    logic [3:0] s4;
    logic m, a7;
    if (r && ($countones(s6) != 3 || (!k && x == 5'd7))) s6 = ~s6;
    m = ($countones(s6) > 3) ? 1'b1 : ($countones(s6) < 3) ? 1'b0 : r;
    a7 = (y == 3'd7) && (k || (!m && (x == 17 || x == 18 || x == 20)) ||
                              (m && (x == 11 || x == 13 || x == 14)));
    s4 = a7 ? 4'b0111 : m4(y);
    if (m && ($countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
    if (k && x == 5'd28 && r && $countones(s4) == 2 && y != 3'd3) s4 = ~s4;
    return {s6, s4};
  endfunction

  function automatic logic [7:0] kByte(input int i);
    logic [4:0] kx [4] = '{5'd23, 5'd27, 5'd29, 5'd30};
    return (i < 8) ? {3'(i), 5'd28} : {3'd7, kx[i-8]};
  endfunction

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step(input logic vld, input logic [11:0] raw, input logic dec, input logic w10,
                      input logic [11:0] eD, input logic eS, input logic eE, input string tag);
    @(negedge clk);
    checks++;
    if (validOut !== pV || dataOut !== pD || specialOut !== pS || errOut !== pE) begin
      fails++;
      $display("FAIL %s: got v=%b d=%h s=%b e=%b exp v=%b d=%h s=%b e=%b",
               pTag, validOut, dataOut, specialOut, errOut, pV, pD, pS, pE);
    end
    charValid = vld; charIn = raw; decEn = dec; wide10 = w10;
    pV = vld;
    pTag = tag;
    if (vld) begin pD = eD; pS = eS; pE = eE; end
  endtask

  task automatic sendDec(input logic [7:0] b, input logic k, input string tag);
    logic [9:0] c = enc(b, k, rd);
    step(1'b1, {2'($urandom), c}, 1'b1, 1'($urandom), {4'h0, b}, k, 1'b0, tag);
    rd = rdAfter(rd, c);
  endtask

  task automatic sendErr(input logic [9:0] c, input string tag);
    step(1'b1, {2'($urandom), c}, 1'b1, 1'($urandom), 12'h000, 1'b1, 1'b1, tag);
    rd = rdAfter(rd, c);
  endtask

  task automatic sendByp(input logic [11:0] raw, input logic w10);
    if (w10) step(1'b1, raw, 1'b0, 1'b1, {2'b00, raw[9:0]}, 1'b0, 1'b0, "R8 raw10");
    else     step(1'b1, raw, 1'b0, 1'b0, raw, 1'b0, 1'b0, "R9 raw12");
  endtask

  task automatic idle();
    step(1'b0, 12'($urandom), 1'($urandom), 1'($urandom), 12'h0, 1'b0, 1'b0, "R2 idle hold");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finishUp();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    step(1'b0, 12'h0, 1'b0, 1'b0, 12'h0, 1'b0, 1'b0, "R1 reset");
    rstN = 1'b1;
    // R1: negative start disparity - first positive-prefix control code must be clean
    sendDec(8'hBC, 1'b1, "R1 R4 first K28.5 at negative");
    sendDec(8'hBC, 1'b1, "R4 K28.5 at positive");
    for (int i = 0; i < 12; i++) sendDec(kByte(i), 1'b1, "R4 control code");
    for (int i = 0; i < 12; i++) sendDec(kByte(i), 1'b1, "R4 control code other side");
    sendDec(8'h4A, 1'b0, "R3 D10.2");
    sendDec(8'hF1, 1'b0, "R3 A7 data");
    idle();
    idle();
    sendErr({6'b000000, 4'b1011}, "R5 empty 6b");
    sendErr({6'b111100, 4'b0100}, "R5 unlisted 6b");
    sendDec(8'h00, 1'b0, "R7 resync after error");
    sendErr({m6(5'd3), 4'b0000}, "R5 empty 4b");
    sendErr({m6(5'd3), 4'b1111}, "R5 full 4b");
    sendDec(8'h15, 1'b0, "R7 after 4b errors");
    sendErr(enc(8'h00, 1'b0, ~rd), "R6 wrong polarity D0.0");
    sendErr(enc(8'h07, 1'b0, ~rd), "R6 wrong polarity D7.0");
    sendDec(8'h27, 1'b0, "R7 after disparity error");
    sendByp(12'hFFF, 1'b0);
    sendByp(12'h3C0, 1'b1);
    sendByp(12'hA55, 1'b0);
    sendDec(8'h00, 1'b0, "R7 R8 R9 disparity kept across bypass");
    sendDec(8'h9C, 1'b0, "R3 data");
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 10);
      if (r == 0) idle();
      else if (r == 1) sendByp(12'($urandom), 1'b1);
      else if (r == 2) sendByp(12'($urandom), 1'b0);
      else if (r == 3) sendDec(kByte(int'($urandom % 12)), 1'b1, "R4 R7 random control");
      else sendDec(8'($urandom), 1'b0, "R3 R7 R10 random data");
    end
    idle();
    idle();
    finishUp();
  end
endmodule